// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with In-Band Parity

This block sends and receives bytes over a pair of asynchronous serial lines at the same time. It has no baud generator of its own. A timer elsewhere on the chip supplies a one-cycle enable pulse at sixteen times the bit rate, and both directions count these pulses. Software-facing logic writes a byte through a strobe and reads the last received byte from a register-like output. Each direction signals completion with its own one-clock pulse, which can be routed to an interrupt controller.

A parity mode changes the meaning of the top data bit in both directions. When it is on, the transmitter replaces bit 7 of the outgoing byte with an odd-parity bit computed over the seven low bits. The receiver then replaces bit 7 of the byte it presents with a flag that reports a failed odd-parity check. No separate status bit is kept. Outgoing characters carry two stop bits. The receiver needs only one stop bit, so frames packed with a single stop bit are accepted.

Top module: `async_duplex`

## Requirements
- R1: When idle, `ser_out` is 1. A transmitted character is one 0 start bit, then bit positions 0 to 7 of the payload with the least significant bit first, then two 1 stop bits.
- R2: With `parity_on` = 1, the payload bit in position 7 is the inverted XOR of `wr_byte[6:0]`, so the eight sent data bits hold an odd number of ones. With `parity_on` = 0, position 7 carries `wr_byte[7]`.
- R3: The receiver accepts a 0 start bit, eight data bits sent least significant bit first, and one 1 stop bit. With `parity_on` = 0, `rd_byte` equals the eight received bits.
- R4: With `parity_on` = 1, `rd_byte[6:0]` holds the seven low received bits. `rd_byte[7]` is 1 exactly when the eight received data bits contain an even number of ones.
- R5: Two characters sent back to back, each followed by only one stop bit, are both received, in order.
- R6: A low level on `ser_in` that no longer holds halfway through the start bit (8 ticks after the falling edge) is discarded. It causes no `rx_irq`, and `rd_byte` is left unchanged.
- R7: A character whose stop bit is sampled as 0 is dropped. It causes no `rx_irq`, `rd_byte` keeps its earlier value, and the next valid character is received normally.
- R8: `tx_irq` pulses for one clock as each transmitted character ends. `rx_irq` pulses for one clock per accepted character. `rd_byte` changes only in the cycle `rx_irq` is high.
- R9: A write is accepted only while `tx_busy` is 0. `tx_busy` is 1 from the cycle after the accepted write until the last stop bit ends. Writes made while busy are ignored: no data change, and no extra character.
- R10: Each serial bit lasts 16 `bit_tick` pulses. When no tick arrives, neither direction advances. Ticks that are sparser than every clock still give correct characters.
- R11: After reset, `ser_out` is 1, `tx_busy`, `tx_irq` and `rx_irq` are 0, and `rd_byte` is 0. A reset in the middle of a frame returns the transmitter to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_tick | input | 1 | Enable pulse at 16 times the bit rate |
| parity_on | input | 1 | Selects the in-band odd-parity mode for both directions |
| wr_stb | input | 1 | Write strobe for the transmit byte |
| wr_byte | input | 8 | Byte to transmit |
| tx_busy | output | 1 | A character is being sent, so writes are ignored |
| tx_irq | output | 1 | One-clock pulse when a character has been sent |
| ser_out | output | 1 | Serial transmit line |
| ser_in | input | 1 | Serial receive line, asynchronous |
| rd_byte | output | 8 | Last received byte, with the parity flag in bit 7 when parity is on |
| rx_irq | output | 1 | One-clock pulse when a character has been received |

## Verification
Two events can coincide: the end of a transmit character, where `tx_irq` pulses and `tx_busy` drops, and the acceptance of a new write. The bench holds `wr_stb` high from the middle of one frame until the busy flag clears. The write must then be taken on exactly the clock after the completion pulse. The next character on the line must carry the new byte, and one completion pulse must be counted for the old character. A single strobe in the middle of a frame must leave both the data and the character count unchanged.

// File: rtl/adx_pkg.sv
// Shared types for the asynchronous duplex serial block.
// Assumes: nothing beyond IEEE 1800-2017.
package adx_pkg;

    // Receiver sequencing states.
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

endpackage

// File: rtl/adx_sync.sv
// Multi-stage synchronizer for an asynchronous single-bit input.
// Assumes: STAGES >= 2; the flops reset to IDLE_VAL (the line's idle level).
module adx_sync #(
    parameter int   STAGES   = 2,
    parameter logic IDLE_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{IDLE_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/adx_tx.sv
// Transmit framer: start bit, DATA_W payload bits LSB first, STOP_BITS stop bits.
// Each bit lasts OVS tick pulses. With parity on, the top payload bit is odd parity
// over the lower bits. Writes are taken only when idle.
// Assumes: tick is a one-cycle enable; OVS is a power of two.
module adx_tx #(
    parameter int DATA_W    = 8,
    parameter int OVS       = 16,
    parameter int STOP_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              par_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              done,
    output logic              line
);
    localparam int FRAME_W = 1 + DATA_W + STOP_BITS;
    localparam int CNT_W   = $clog2(OVS);
    localparam int BIT_W   = $clog2(FRAME_W);

    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   tcnt;
    logic [BIT_W-1:0]   bcnt;
    logic               active;
    logic [DATA_W-1:0]  payload;

    // Build the payload, putting odd parity in the top bit when enabled.
    always_comb begin
        payload = wr_data;
        if (par_en) payload[DATA_W-1] = ~(^wr_data[DATA_W-2:0]);
    end

    // Load a frame on an idle write, then shift one bit every OVS ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '1;
            tcnt   <= '0;
            bcnt   <= '0;
            active <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (wr_en) begin
                    shreg  <= {{STOP_BITS{1'b1}}, payload, 1'b0};
                    active <= 1'b1;
                    tcnt   <= '0;
                    bcnt   <= '0;
                end
            end else if (tick) begin
                if (tcnt == CNT_W'(OVS - 1)) begin
                    tcnt  <= '0;
                    shreg <= {1'b1, shreg[FRAME_W-1:1]};
                    if (bcnt == BIT_W'(FRAME_W - 1)) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                        bcnt   <= '0;
                    end else begin
                        bcnt <= bcnt + 1'b1;
                    end
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
            end
        end
    end

    assign line = shreg[0];
    assign busy = active;

    // R1: the line rests high whenever no frame is in flight
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> line);
    // R8: completion pulse lasts one clock
    a_r8_tx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: a write during a frame does not end or restart it
    a_r9_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && !tick) |=> (busy && $stable(line)));
    // R10: without a tick the line holds its level mid-frame
    a_r10_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> $stable(line));
endmodule

// File: rtl/adx_rx.sv
// Receive deframer with start-bit qualification at mid-bit, mid-bit data sampling
// and a check of one stop bit. With parity on, the top output bit is replaced by
// an odd-parity error flag.
// Assumes: rx_in is already synchronized; tick is a one-cycle enable at OVS x bit rate.
module adx_rx
    import adx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              par_en,
    input  logic              rx_in,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_done
);
    localparam int CNT_W = $clog2(OVS);
    localparam int BIT_W = $clog2(DATA_W);
    localparam int HALF  = OVS / 2;

    rx_state_e         state;
    logic              prev;
    logic [CNT_W-1:0]  tcnt;
    logic [BIT_W-1:0]  bcnt;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] checked;

    // Form the presented byte, substituting the parity-error flag when enabled.
    always_comb begin
        checked = shreg;
        if (par_en) checked[DATA_W-1] = ~(^shreg);
    end

    // Sequence through start qualification, data sampling and stop check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RX_IDLE;
            prev    <= 1'b1;
            tcnt    <= '0;
            bcnt    <= '0;
            shreg   <= '0;
            rx_data <= '0;
            rx_done <= 1'b0;
        end else begin
            rx_done <= 1'b0;
            prev    <= rx_in;
            case (state)
                RX_IDLE: begin
                    if (prev && !rx_in) begin
                        state <= RX_START;
                        tcnt  <= '0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (tcnt == CNT_W'(HALF - 1)) begin
                            tcnt <= '0;
                            bcnt <= '0;
                            state <= rx_in ? RX_IDLE : RX_DATA;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        if (tcnt == CNT_W'(OVS - 1)) begin
                            tcnt  <= '0;
                            shreg <= {rx_in, shreg[DATA_W-1:1]};
                            if (bcnt == BIT_W'(DATA_W - 1)) state <= RX_STOP;
                            else                            bcnt  <= bcnt + 1'b1;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        if (tcnt == CNT_W'(OVS - 1)) begin
                            tcnt  <= '0;
                            state <= RX_IDLE;
                            if (rx_in) begin
                                rx_data <= checked;
                                rx_done <= 1'b1;
                            end
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    // R8: one-clock receive pulse
    a_r8_rx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);
    // R8: the presented byte moves only with the receive pulse
    a_r8_rx_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_done |-> $stable(rx_data));
    // R6: a start bit that is high again at mid-bit sends the receiver back to idle
    a_r6_glitch_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_START && tick && tcnt == CNT_W'(HALF - 1) && rx_in) |=>
        (state == RX_IDLE && !rx_done));
    // R7: a low stop bit gives no receive pulse
    a_r7_frame_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_STOP && tick && tcnt == CNT_W'(OVS - 1) && !rx_in) |=>
        !rx_done);
endmodule

// File: rtl/async_duplex.sv
// Full-duplex asynchronous serial transceiver paced by an external tick at OVS x
// bit rate. It joins the transmit framer, the input synchronizer and the receive deframer.
// Assumes: bit_tick comes from a timer in the same clock domain; ser_in is asynchronous.
module async_duplex #(
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int TX_STOP     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              parity_on,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_byte,
    output logic              tx_busy,
    output logic              tx_irq,
    output logic              ser_out,
    input  logic              ser_in,
    output logic [DATA_W-1:0] rd_byte,
    output logic              rx_irq
);
    logic rx_sync;

    adx_tx #(.DATA_W(DATA_W), .OVS(OVS), .STOP_BITS(TX_STOP)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (bit_tick),
        .par_en  (parity_on),
        .wr_en   (wr_stb),
        .wr_data (wr_byte),
        .busy    (tx_busy),
        .done    (tx_irq),
        .line    (ser_out)
    );

    adx_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ser_in),
        .q     (rx_sync)
    );

    adx_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (bit_tick),
        .par_en  (parity_on),
        .rx_in   (rx_sync),
        .rx_data (rd_byte),
        .rx_done (rx_irq)
    );
endmodule

// File: tb/sim_async_duplex.sv
module sim_async_duplex;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n, bit_tick, parity_on, wr_stb;
    logic [7:0] wr_byte, rd_byte;
    logic       tx_busy, tx_irq, ser_out, ser_in, rx_irq;
    logic       loop_sel, rx_drv;
    assign ser_in = loop_sel ? ser_out : rx_drv;

    async_duplex u0 (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .parity_on(parity_on),
        .wr_stb(wr_stb), .wr_byte(wr_byte), .tx_busy(tx_busy), .tx_irq(tx_irq),
        .ser_out(ser_out), .ser_in(ser_in), .rd_byte(rd_byte), .rx_irq(rx_irq)
    );

    int vectors = 0, errors = 0;
    int tick_div = 1, tick_ph = 0;
    bit tick_en = 1'b1;
    int rx_cnt = 0, tx_cnt = 0;
    logic [7:0] rx_prev = 8'h00, rx_last = 8'h00;

    // Tick generator, updated away from the active edge
    always @(negedge clk) begin
        if (!tick_en)           bit_tick = 1'b0;
        else if (tick_div <= 1) bit_tick = 1'b1;
        else begin
            bit_tick = (tick_ph == 0);
            tick_ph  = (tick_ph + 1) % tick_div;
        end
    end

    // Pulse monitors
    always @(negedge clk) begin
        if (rst_n && rx_irq) begin rx_cnt++; rx_prev = rx_last; rx_last = rd_byte; end
        if (rst_n && tx_irq) tx_cnt++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] tx_payload(input logic [7:0] d, input logic p);
        return p ? {~(^d[6:0]), d[6:0]} : d;
    endfunction

    // Write a byte; optionally check each bit level at its middle (tick every clock)
    task automatic tx_frame(input logic [7:0] d, input bit wave);
        logic [7:0] pd;
        logic       expb;
        pd = tx_payload(d, parity_on);
        @(negedge clk); wr_byte = d; wr_stb = 1'b1;
        @(negedge clk); wr_stb = 1'b0;
        check("R9 busy after write", tx_busy, 1);
        if (wave) begin
            repeat (8) @(posedge clk);
            @(negedge clk);
            for (int k = 0; k < 11; k++) begin
                if (k == 0)      expb = 1'b0;
                else if (k <= 8) expb = pd[k-1];
                else             expb = 1'b1;
                check((k == 8) ? "R2 parity position" : "R1 frame bit", ser_out, expb);
                if (k < 10) begin repeat (16) @(posedge clk); @(negedge clk); end
            end
        end
        while (tx_busy) @(negedge clk);
        wait_n(3);
    endtask

    // Drive a frame onto the receive line directly
    task automatic rx_frame(input logic [7:0] b, input logic stopv);
        rx_drv = 1'b0; wait_n(16);
        for (int i = 0; i < 8; i++) begin rx_drv = b[i]; wait_n(16); end
        rx_drv = stopv; wait_n(16);
        rx_drv = 1'b1;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        errors++; vectors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        int c0, t0;
        logic [7:0] keep;
        rst_n = 1'b0; bit_tick = 1'b0; parity_on = 1'b0; wr_stb = 1'b0; wr_byte = 8'h00;
        loop_sel = 1'b1; rx_drv = 1'b1;
        wait_n(5); rst_n = 1'b1; wait_n(2);
        // R11 reset state
        check("R11 ser_out idle", ser_out, 1);
        check("R11 tx_busy", tx_busy, 0);
        check("R11 rd_byte", rd_byte, 0);
        check("R11 irqs", {tx_irq, rx_irq}, 0);

        // R11 reset mid-frame
        @(negedge clk); wr_byte = 8'h00; wr_stb = 1'b1;
        @(negedge clk); wr_stb = 1'b0; wait_n(40);
        rst_n = 1'b0; wait_n(2); rst_n = 1'b1; wait_n(1);
        check("R11 reset mid-frame line", ser_out, 1);
        check("R11 reset mid-frame busy", tx_busy, 0);
        wait_n(200);
        rx_cnt = 0; tx_cnt = 0;

        // R1 R2 R3 R4 R8: loopback sweep over every byte, both parity modes
        for (int p = 0; p < 2; p++) begin
            parity_on = p[0];
            for (int d = 0; d < 256; d++) begin
                c0 = rx_cnt; t0 = tx_cnt;
                tx_frame(d[7:0], 1'b1);
                check("R3 one rx per char", rx_cnt, c0 + 1);
                check("R8 one tx per char", tx_cnt, t0 + 1);
                check(p ? "R4 loopback parity ok" : "R3 loopback data", rd_byte,
                      p ? {1'b0, d[6:0]} : d[7:0]);
            end
        end

        // R10: ticks withheld freeze the frame, then sparse ticks still work
        parity_on = 1'b0; tick_en = 1'b0; t0 = tx_cnt; c0 = rx_cnt;
        @(negedge clk); wr_byte = 8'hC3; wr_stb = 1'b1;
        @(negedge clk); wr_stb = 1'b0; wait_n(100);
        check("R10 frozen busy", tx_busy, 1);
        check("R10 frozen start bit", ser_out, 0);
        check("R10 frozen no irq", tx_cnt, t0);
        tick_en = 1'b1;
        while (tx_busy) @(negedge clk);
        wait_n(3);
        check("R10 resumed data", rd_byte, 8'hC3);
        tick_div = 3;
        tx_frame(8'h6E, 1'b0);
        check("R10 sparse tick data", rd_byte, 8'h6E);
        check("R10 sparse tick count", rx_cnt, c0 + 2);
        tick_div = 1;

        // R9: single strobe mid-frame is ignored
        c0 = rx_cnt;
        @(negedge clk); wr_byte = 8'h5A; wr_stb = 1'b1;
        @(negedge clk); wr_stb = 1'b0; wait_n(50);
        wr_byte = 8'hA7; wr_stb = 1'b1; @(negedge clk); wr_stb = 1'b0;
        while (tx_busy) @(negedge clk);
        wait_n(200);
        check("R9 ignored write data", rd_byte, 8'h5A);
        check("R9 no extra char", rx_cnt, c0 + 1);
        check("R9 line idle", ser_out, 1);

        // R9 R8: write held across completion is taken in the tx_irq cycle
        c0 = rx_cnt; t0 = tx_cnt;
        @(negedge clk); wr_byte = 8'h11; wr_stb = 1'b1;
        @(negedge clk); wr_byte = 8'h9E; wait_n(60);
        while (tx_busy) @(negedge clk);
        check("R8 irq with busy drop", tx_irq, 1);
        @(negedge clk); wr_stb = 1'b0;
        check("R9 boundary write taken", tx_busy, 1);
        check("R8 first char counted", tx_cnt, t0 + 1);
        check("R9 first char data", rd_byte, 8'h11);
        while (tx_busy) @(negedge clk);
        wait_n(3);
        check("R9 boundary char data", rd_byte, 8'h9E);
        check("R8 boundary counts", rx_cnt, c0 + 2);

        // R4: direct-drive parity flag over 64 raw bytes
        loop_sel = 1'b0; parity_on = 1'b1; wait_n(20);
        for (int i = 0; i < 64; i++) begin
            logic [7:0] b;
            b = 8'((i * 37 + 3) & 255);
            c0 = rx_cnt;
            rx_frame(b, 1'b1); wait_n(4);
            check("R4 rx count", rx_cnt, c0 + 1);
            check("R4 parity flag", rd_byte, {~(^b), b[6:0]});
        end

        // R5: back-to-back, single stop bit
        parity_on = 1'b0; c0 = rx_cnt;
        rx_frame(8'hA5, 1'b1); rx_frame(8'h3C, 1'b1); wait_n(20);
        check("R5 both received", rx_cnt, c0 + 2);
        check("R5 first byte", rx_prev, 8'hA5);
        check("R5 second byte", rx_last, 8'h3C);

        // R6: short low glitch
        keep = rd_byte; c0 = rx_cnt;
        rx_drv = 1'b0; wait_n(5); rx_drv = 1'b1; wait_n(200);
        check("R6 glitch no irq", rx_cnt, c0);
        check("R6 glitch data kept", rd_byte, keep);

        // R7: framing error then recovery
        rx_frame(8'h5A, 1'b0); wait_n(40);
        check("R7 bad stop no irq", rx_cnt, c0);
        check("R7 bad stop data kept", rd_byte, keep);
        rx_frame(8'h99, 1'b1); wait_n(20);
        check("R7 recovery count", rx_cnt, c0 + 1);
        check("R7 recovery data", rd_byte, 8'h99);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule